// File: doc/BRIEF.md
# Hysteresis DMA-Request FIFO

This block is a single-clock first-in first-out store for 16-bit words. A small two-register interface controls it. Each word pushed into the store comes from one of four data inputs, chosen by a configuration field. A single request line tells an external bus-master DMA engine when to move data. That line can be driven by one of two hysteresis flags, or by a plain not-empty or not-full condition.

The hysteresis flags have separate raise and drop thresholds. The free-space flag rises once at least 256 words are free and drops once fewer than 128 are free. The stored-data flag follows the same rule applied to the occupancy. This gives every burst at least 128 words. It also leaves a wide margin for a DMA engine that completes one more transfer after the request falls.

The control register holds the enable bit. While the enable bit is clear, the store is flushed and the request is held low.

The control path is built from two small state machines. The control state machine has two states, `CTL_OFF` and `CTL_ON`. It moves `CTL_OFF -> CTL_ON` when the control register is written with bit 0 set, and `CTL_ON -> CTL_OFF` when it is written with bit 0 clear. Each hysteresis flag is an instance of one flag state machine with two states, `HY_LOW` and `HY_HIGH`. It moves `HY_LOW -> HY_HIGH` when the level is at or above the raise mark. It moves `HY_HIGH -> HY_LOW` when the level is below the drop mark. It is forced to `HY_LOW` whenever the block is disabled.

Top module: `hyst_dma_fifo`

## Requirements
- R1: After reset, both registers read 0 and `dma_req`, `ovf_err` and `unf_err` are 0.
- R2: `reg_addr` 0 selects the control register and `reg_addr` 1 selects the configuration register. In the control register, bit 0 is the enable (read/write), bit 9 is the free-space flag and bit 8 is the stored-data flag; every other bit reads 0. In the configuration register, bits 9:8 are the request select and bits 1:0 are the input select; every other bit is discarded and reads 0. `reg_rdata` is a combinational read of the addressed register.
- R3: `pop_data` always shows the oldest stored word. A pop removes that word, and words leave in the order they were pushed.
- R4: The input select picks the data that a push stores: 0 selects `host_wdata`, 1 selects `port_a_data`, 2 selects `port_b_data` and 3 selects `alt_data`.
- R5: The free-space flag (free = 1024 − occupancy) sets when free ≥ 256, clears when free < 128, and otherwise holds its value.
- R6: The stored-data flag sets when occupancy ≥ 256, clears when occupancy < 128, and otherwise holds its value.
- R7: Both flags are registered. Each reacts one clock after the occupancy that triggers it.
- R8: When enabled, `dma_req` follows the source chosen by the request select: 0 selects the stored-data flag, 1 selects not-empty, 2 selects the free-space flag and 3 selects not-full.
- R9: While the enable bit is 0, the store is empty, pushes and pops are ignored, `dma_req` is 0, both flags fall to 0 and both error bits clear.
- R10: A push while the store holds 1024 words is dropped, even if a pop is made in the same cycle. The stored data is unchanged, and `ovf_err` sets and stays set while the block is enabled.
- R11: A pop while the store is empty is ignored, and `unf_err` sets and stays set while the block is enabled.
- R12: A push and a pop in the same cycle, with the store neither empty nor full, leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 configuration |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the addressed register |
| host_wdata | input | 16 | Push data from the host bus |
| port_a_data | input | 16 | Push data from port A |
| port_b_data | input | 16 | Push data from port B |
| alt_data | input | 16 | Alternate or loopback push data |
| fifo_push | input | 1 | Push one word this cycle |
| fifo_pop | input | 1 | Pop one word this cycle |
| pop_data | output | 16 | Oldest stored word |
| dma_req | output | 1 | Request line to the DMA engine |
| ovf_err | output | 1 | Sticky overflow indication |
| unf_err | output | 1 | Sticky underflow indication |

## Verification
The occupancy is ramped up and down in single steps that stop one word short of each threshold, exactly on it, and one word past it. The flag is sampled both in the cycle the threshold is crossed and one cycle later. This separates a correct two-threshold flag from a single-threshold flag, from an off-by-one comparison, and from an unregistered flag.

The same ramps are repeated under each of the four request selects, so a swapped select encoding shows up. Pushes at full occupancy and pops at empty occupancy check that nothing is stored or lost, and that the sticky error bits behave as required. A simultaneous push and pop at one word of occupancy shows that the occupancy is held. One push from each data input shows that the input select encoding is correct.

// File: rtl/hdf_pkg.sv
package hdf_pkg;

    localparam int REG_W = 16;

    // register addresses
    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_CFG  = 1'b1;

    // field positions
    localparam int CTRL_ENA_BIT = 0;
    localparam int CTRL_RD_BIT  = 8;
    localparam int CTRL_WR_BIT  = 9;
    localparam int CFG_REQ_LSB  = 8;
    localparam int CFG_IN_LSB   = 0;

    localparam logic [REG_W-1:0] CFG_MASK = 16'h0303;

    typedef enum logic [1:0] {
        REQ_RD = 2'd0,
        REQ_NE = 2'd1,
        REQ_WR = 2'd2,
        REQ_NF = 2'd3
    } req_src_e;

    typedef enum logic [1:0] {
        IN_HOST = 2'd0,
        IN_PA   = 2'd1,
        IN_PB   = 2'd2,
        IN_ALT  = 2'd3
    } in_src_e;

    typedef enum logic {
        CTL_OFF = 1'b0,
        CTL_ON  = 1'b1
    } ctl_state_e;

    typedef enum logic {
        HY_LOW  = 1'b0,
        HY_HIGH = 1'b1
    } hy_state_e;

endpackage

// File: rtl/hdf_regs.sv
module hdf_regs
    import hdf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic             reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             wr_flag,
    input  logic             rd_flag,
    output logic             ena,
    output logic [1:0]       req_sel,
    output logic [1:0]       in_sel,
    output logic [REG_W-1:0] reg_rdata
);

    ctl_state_e        ctl_q, ctl_nx;
    logic [REG_W-1:0]  cfg_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= CTL_OFF;
        end else begin
            ctl_q <= ctl_nx;
        end
    end

    // next state
    always_comb begin
        ctl_nx = ctl_q;
        unique case (ctl_q)
            CTL_OFF: if (reg_we && reg_addr == ADDR_CTRL && reg_wdata[CTRL_ENA_BIT])
                         ctl_nx = CTL_ON;
            CTL_ON:  if (reg_we && reg_addr == ADDR_CTRL && !reg_wdata[CTRL_ENA_BIT])
                         ctl_nx = CTL_OFF;
        endcase
    end

    // configuration word, reserved bits dropped on write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (reg_we && reg_addr == ADDR_CFG) begin
            cfg_q <= reg_wdata & CFG_MASK;
        end
    end

    // outputs
    always_comb begin
        ena       = (ctl_q == CTL_ON);
        req_sel   = cfg_q[CFG_REQ_LSB +: 2];
        in_sel    = cfg_q[CFG_IN_LSB +: 2];
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[CTRL_ENA_BIT] = ena;
                reg_rdata[CTRL_WR_BIT]  = wr_flag;
                reg_rdata[CTRL_RD_BIT]  = rd_flag;
            end
            ADDR_CFG: reg_rdata = cfg_q;
        endcase
    end

endmodule

// File: rtl/hdf_store.sv
module hdf_store #(
    parameter int W     = 16,
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ena,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] used,
    output logic          ovf,
    output logic          unf
);

    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_IX  = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr_q, rptr_q;
    logic [CW-1:0] used_q;
    logic          ovf_q, unf_q;
    logic          full, empty, push_ok, pop_ok;

    always_comb begin
        full    = (used_q == FULL_LVL);
        empty   = (used_q == '0);
        push_ok = ena && push && !full;
        pop_ok  = ena && pop && !empty;
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wptr_q] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !ena) begin
            wptr_q <= '0;
            rptr_q <= '0;
            used_q <= '0;
            ovf_q  <= 1'b0;
            unf_q  <= 1'b0;
        end else begin
            if (push_ok) begin
                wptr_q <= (wptr_q == LAST_IX) ? '0 : wptr_q + AW'(1);
            end
            if (pop_ok) begin
                rptr_q <= (rptr_q == LAST_IX) ? '0 : rptr_q + AW'(1);
            end
            unique case ({push_ok, pop_ok})
                2'b10:   used_q <= used_q + CW'(1);
                2'b01:   used_q <= used_q - CW'(1);
                default: used_q <= used_q;
            endcase
            ovf_q <= ovf_q || (push && full);
            unf_q <= unf_q || (pop && empty);
        end
    end

    assign rdata = mem[rptr_q];
    assign used  = used_q;
    assign ovf   = ovf_q;
    assign unf   = unf_q;

endmodule

// File: rtl/hdf_hyst.sv
module hdf_hyst
    import hdf_pkg::*;
#(
    parameter int DEPTH        = 1024,
    parameter int RAISE_AT     = 256,
    parameter int DROP_BELOW   = 128,
    parameter bit MEASURE_FREE = 1'b0,
    localparam int CW          = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ena,
    input  logic [CW-1:0] used,
    output logic          flag
);

    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
    localparam logic [CW-1:0] HI_LVL   = CW'(RAISE_AT);
    localparam logic [CW-1:0] LO_LVL   = CW'(DROP_BELOW);

    logic [CW-1:0] level;
    hy_state_e     st_q, st_nx;

    generate
        if (MEASURE_FREE) begin : g_free
            assign level = FULL_LVL - used;
        end else begin : g_used
            assign level = used;
        end
    endgenerate

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= HY_LOW;
        end else begin
            st_q <= st_nx;
        end
    end

    // next state
    always_comb begin
        st_nx = st_q;
        if (!ena) begin
            st_nx = HY_LOW;
        end else begin
            unique case (st_q)
                HY_LOW:  if (level >= HI_LVL) st_nx = HY_HIGH;
                HY_HIGH: if (level <  LO_LVL) st_nx = HY_LOW;
            endcase
        end
    end

    // output
    always_comb begin
        flag = (st_q == HY_HIGH);
    end

endmodule

// File: rtl/hyst_dma_fifo.sv
module hyst_dma_fifo
    import hdf_pkg::*;
#(
    parameter int W          = 16,
    parameter int DEPTH      = 1024,
    parameter int RAISE_AT   = 256,
    parameter int DROP_BELOW = 128,
    localparam int CW        = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic             reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [W-1:0]     host_wdata,
    input  logic [W-1:0]     port_a_data,
    input  logic [W-1:0]     port_b_data,
    input  logic [W-1:0]     alt_data,
    input  logic             fifo_push,
    input  logic             fifo_pop,
    output logic [W-1:0]     pop_data,
    output logic             dma_req,
    output logic             ovf_err,
    output logic             unf_err
);

    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

    logic          ena;
    logic [1:0]    req_sel, in_sel;
    logic          wr_flag, rd_flag;
    logic [CW-1:0] used_cnt;
    logic [W-1:0]  push_word;
    logic          src_sig;

    hdf_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .wr_flag   (wr_flag),
        .rd_flag   (rd_flag),
        .ena       (ena),
        .req_sel   (req_sel),
        .in_sel    (in_sel),
        .reg_rdata (reg_rdata)
    );

    always_comb begin
        push_word = host_wdata;
        unique case (in_sel)
            IN_HOST: push_word = host_wdata;
            IN_PA:   push_word = port_a_data;
            IN_PB:   push_word = port_b_data;
            IN_ALT:  push_word = alt_data;
        endcase
    end

    hdf_store #(.W(W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .ena   (ena),
        .push  (fifo_push),
        .pop   (fifo_pop),
        .wdata (push_word),
        .rdata (pop_data),
        .used  (used_cnt),
        .ovf   (ovf_err),
        .unf   (unf_err)
    );

    hdf_hyst #(.DEPTH(DEPTH), .RAISE_AT(RAISE_AT), .DROP_BELOW(DROP_BELOW),
               .MEASURE_FREE(1'b1)) u_wr_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .ena   (ena),
        .used  (used_cnt),
        .flag  (wr_flag)
    );

    hdf_hyst #(.DEPTH(DEPTH), .RAISE_AT(RAISE_AT), .DROP_BELOW(DROP_BELOW),
               .MEASURE_FREE(1'b0)) u_rd_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .ena   (ena),
        .used  (used_cnt),
        .flag  (rd_flag)
    );

    always_comb begin
        src_sig = rd_flag;
        unique case (req_sel)
            REQ_RD: src_sig = rd_flag;
            REQ_NE: src_sig = (used_cnt != '0);
            REQ_WR: src_sig = wr_flag;
            REQ_NF: src_sig = (used_cnt != FULL_LVL);
        endcase
        dma_req = ena && src_sig;
    end

endmodule

// File: rtl/hdf_checker.sv
module hdf_checker #(
    parameter int DEPTH      = 1024,
    parameter int RAISE_AT   = 256,
    parameter int DROP_BELOW = 128,
    localparam int CW        = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ena,
    input logic          push,
    input logic          pop,
    input logic [CW-1:0] used,
    input logic          wr_flag,
    input logic          rd_flag,
    input logic          dma_req,
    input logic          ovf,
    input logic          unf
);

    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
    localparam logic [CW-1:0] HI_LVL   = CW'(RAISE_AT);
    localparam logic [CW-1:0] LO_LVL   = CW'(DROP_BELOW);

    logic [CW-1:0] free_lvl;
    assign free_lvl = FULL_LVL - used;

    a_r9_req_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ena |-> !dma_req);

    a_r9_flags_drop_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ena |=> (!wr_flag && !rd_flag && !ovf && !unf && used == '0));

    a_r6_rd_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (ena && used >= HI_LVL) |=> rd_flag);

    a_r6_rd_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ena && used < LO_LVL) |=> !rd_flag);

    a_r6_rd_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ena && used >= LO_LVL && used < HI_LVL) |=> (rd_flag == $past(rd_flag)));

    a_r5_wr_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (ena && free_lvl >= HI_LVL) |=> wr_flag);

    a_r5_wr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ena && free_lvl < LO_LVL) |=> !wr_flag);

    a_r10_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (ena && used == FULL_LVL && !pop) |=> (used == FULL_LVL));

    a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ena && ovf) |=> ovf);

    a_r10_ovf_on_full_push: assert property (@(posedge clk) disable iff (!rst_n)
        (ena && push && used == FULL_LVL) |=> ovf);

    a_r11_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ena && used == '0 && pop && !push) |=> (used == '0 && unf));

    a_r11_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ena && unf) |=> unf);

    a_r12_push_pop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ena && push && pop && used != '0 && used != FULL_LVL) |=> $stable(used));

endmodule

bind hyst_dma_fifo hdf_checker #(
    .DEPTH      (DEPTH),
    .RAISE_AT   (RAISE_AT),
    .DROP_BELOW (DROP_BELOW)
) u_hdf_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .ena     (ena),
    .push    (fifo_push),
    .pop     (fifo_pop),
    .used    (used_cnt),
    .wr_flag (wr_flag),
    .rd_flag (rd_flag),
    .dma_req (dma_req),
    .ovf     (ovf_err),
    .unf     (unf_err)
);

// File: tb/test_hyst_dma_fifo.sv
module test_hyst_dma_fifo;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_addr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [15:0] host_wdata = '0;
    logic [15:0] port_a_data = 16'hA1A1;
    logic [15:0] port_b_data = 16'hB2B2;
    logic [15:0] alt_data = 16'hC3C3;
    logic        fifo_push = 1'b0;
    logic        fifo_pop = 1'b0;
    logic [15:0] pop_data;
    logic        dma_req;
    logic        ovf_err;
    logic        unf_err;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int push_idx = 0;
    int pop_idx = 0;

    always #10 clk = ~clk;

    hyst_dma_fifo i_hyst_dma_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .host_wdata  (host_wdata),
        .port_a_data (port_a_data),
        .port_b_data (port_b_data),
        .alt_data    (alt_data),
        .fifo_push   (fifo_push),
        .fifo_pop    (fifo_pop),
        .pop_data    (pop_data),
        .dma_req     (dma_req),
        .ovf_err     (ovf_err),
        .unf_err     (unf_err)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run hung after %0d cycles", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic a, input logic [15:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic read_reg(input logic a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // vector fields: [17:16] kind (0 idle, 1 push, 2 pop), [15:5] cycles,
    // [4:3] request select, [2] expected free-space flag, [1] expected data flag, [0] expected dma_req
    localparam int NV = 17;
    localparam logic [17:0] VEC [NV] = '{
        {2'd0, 11'd1,   2'd1, 1'b1, 1'b0, 1'b0},  // empty, not-empty low (R8)
        {2'd1, 11'd1,   2'd1, 1'b1, 1'b0, 1'b1},  // one word, not-empty high (R8)
        {2'd1, 11'd254, 2'd0, 1'b1, 1'b0, 1'b0},  // 255 stored, below raise mark (R6)
        {2'd1, 11'd1,   2'd0, 1'b1, 1'b0, 1'b0},  // 256 reached, flag not yet (R7)
        {2'd0, 11'd1,   2'd0, 1'b1, 1'b1, 1'b1},  // one cycle later it sets (R7)
        {2'd2, 11'd128, 2'd0, 1'b1, 1'b1, 1'b1},  // 128 stored, still held (R6)
        {2'd2, 11'd1,   2'd0, 1'b1, 1'b1, 1'b1},  // 127 stored, flag lags (R7)
        {2'd0, 11'd1,   2'd0, 1'b1, 1'b0, 1'b0},  // clears (R6)
        {2'd1, 11'd128, 2'd0, 1'b1, 1'b0, 1'b0},  // 255 stored, stays low (R6)
        {2'd1, 11'd641, 2'd2, 1'b1, 1'b1, 1'b1},  // 896 stored, free 128 (R5)
        {2'd1, 11'd1,   2'd2, 1'b1, 1'b1, 1'b1},  // free 127, flag lags (R7)
        {2'd0, 11'd1,   2'd2, 1'b0, 1'b1, 1'b0},  // free-space flag clears (R5)
        {2'd2, 11'd128, 2'd2, 1'b0, 1'b1, 1'b0},  // free 255 still low (R5)
        {2'd2, 11'd1,   2'd2, 1'b0, 1'b1, 1'b0},  // free 256 reached (R7)
        {2'd0, 11'd1,   2'd2, 1'b1, 1'b1, 1'b1},  // sets a cycle later (R5)
        {2'd1, 11'd256, 2'd3, 1'b0, 1'b1, 1'b0},  // full, not-full low (R8)
        {2'd0, 11'd1,   2'd1, 1'b0, 1'b1, 1'b1}   // full, not-empty high (R8)
    };

    initial begin
        logic [15:0] rd;
        logic [17:0] v;

        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        tick();

        // R1 reset state
        read_reg(1'b0, rd); chk("R1 control after reset", rd, 16'h0000);
        read_reg(1'b1, rd); chk("R1 config after reset", rd, 16'h0000);
        chk("R1 dma_req after reset", {15'b0, dma_req}, 16'h0000);
        chk("R1 errors after reset", {14'b0, ovf_err, unf_err}, 16'h0000);

        reg_write(1'b0, 16'h0001);

        for (int vi = 0; vi < NV; vi++) begin
            v = VEC[vi];
            for (int c = 0; c < int'(v[15:5]); c++) begin
                if (c == 0) begin
                    reg_we = 1'b1; reg_addr = 1'b1;
                    reg_wdata = {6'b0, v[4:3], 8'b0};
                end
                fifo_push  = (v[17:16] == 2'd1);
                fifo_pop   = (v[17:16] == 2'd2);
                host_wdata = push_idx[15:0];
                if (fifo_pop) chk("R3 pop order", pop_data, pop_idx[15:0]);
                tick();
                reg_we = 1'b0;
                if (fifo_push) push_idx = push_idx + 1;
                if (fifo_pop)  pop_idx = pop_idx + 1;
            end
            fifo_push = 1'b0;
            fifo_pop  = 1'b0;
            read_reg(1'b0, rd);
            chk("R5 R7 free-space flag", {15'b0, rd[9]}, {15'b0, v[2]});
            chk("R6 R7 stored-data flag", {15'b0, rd[8]}, {15'b0, v[1]});
            chk("R8 dma_req source", {15'b0, dma_req}, {15'b0, v[0]});
        end

        // R10 push while full is dropped
        host_wdata = 16'hDEAD;
        fifo_push = 1'b1;
        tick();
        fifo_push = 1'b0;
        chk("R10 overflow set", {15'b0, ovf_err}, 16'h0001);
        chk("R10 head untouched", pop_data, pop_idx[15:0]);
        chk("R11 no underflow", {15'b0, unf_err}, 16'h0000);
        tick();
        chk("R10 overflow sticky", {15'b0, ovf_err}, 16'h0001);

        // R9 disable flushes and forces request low
        reg_write(1'b1, 16'h0300);
        reg_write(1'b0, 16'h0000);
        fifo_push = 1'b1;
        tick();
        fifo_push = 1'b0;
        read_reg(1'b0, rd); chk("R9 control while off", rd, 16'h0000);
        chk("R9 dma_req off", {15'b0, dma_req}, 16'h0000);
        chk("R9 errors cleared", {14'b0, ovf_err, unf_err}, 16'h0000);
        reg_write(1'b1, 16'h0100);
        reg_write(1'b0, 16'h0001);
        chk("R9 store flushed", {15'b0, dma_req}, 16'h0000);

        // R11 pop while empty
        fifo_pop = 1'b1;
        tick();
        fifo_pop = 1'b0;
        chk("R11 underflow set", {15'b0, unf_err}, 16'h0001);
        chk("R11 still empty", {15'b0, dma_req}, 16'h0000);

        // R4 input select
        reg_write(1'b1, 16'h0101); fifo_push = 1'b1; tick(); fifo_push = 1'b0;
        reg_write(1'b1, 16'h0102); fifo_push = 1'b1; tick(); fifo_push = 1'b0;
        reg_write(1'b1, 16'h0103); fifo_push = 1'b1; tick(); fifo_push = 1'b0;
        reg_write(1'b1, 16'h0100); host_wdata = 16'h0D0D;
        fifo_push = 1'b1; tick(); fifo_push = 1'b0;
        chk("R4 port A word", pop_data, 16'hA1A1);
        fifo_pop = 1'b1; tick();
        chk("R4 port B word", pop_data, 16'hB2B2);
        tick();
        chk("R4 alternate word", pop_data, 16'hC3C3);
        tick();
        chk("R4 host word", pop_data, 16'h0D0D);

        // R12 simultaneous push and pop with one word stored
        host_wdata = 16'h5A5A;
        fifo_push = 1'b1;
        tick();
        fifo_push = 1'b0;
        fifo_pop = 1'b0;
        chk("R12 new head", pop_data, 16'h5A5A);
        chk("R12 one word kept", {15'b0, dma_req}, 16'h0001);
        fifo_pop = 1'b1; tick(); fifo_pop = 1'b0;
        chk("R12 empty after last pop", {15'b0, dma_req}, 16'h0000);

        // R2 reserved bits
        reg_write(1'b1, 16'hFFFF);
        read_reg(1'b1, rd); chk("R2 config reserved bits", rd, 16'h0303);
        reg_write(1'b0, 16'hFFFF);
        read_reg(1'b0, rd); chk("R2 control layout", rd, 16'h0201);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule